// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block keeps one 16-bit control word for each interrupt source and picks, every clock, the one source that should be serviced next. Each word holds an enable, a pending flag, a 4-bit priority level and a 2-bit group level. Peripherals set the pending flags with single-cycle request pulses. Software can read and write every word through a simple register port, and a write to the pending flag counts like a hardware event. The CPU reports its own running priority level. It also reports service entry through an acknowledge, which states whether the service is a normal CPU interrupt or a peripheral event controller transfer, and whether that transfer just used up its count.

Arbitration has two stages. The source with the highest priority level wins. Among sources at that level, the highest group level wins, and a full tie goes to the lowest source index. The winner is offered to the CPU only when its level is strictly above the current CPU level. The winner's index, level and valid bit are registered, so they reflect the control state one clock later.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every control word reads 0x0000 and `irq_valid` is 0.
- R2: A control word is laid out as group level in bits 1:0, priority level in bits 5:2, enable in bit 6 and pending flag in bit 7. A write stores bits 7:0, and bits 15:8 always read as zero.
- R3: A one-cycle pulse on `hw_req[i]` sets the pending flag (bit 7) of source i at that clock edge.
- R4: An acknowledge with `ack_pec`=0 clears the pending flag of source `ack_src`.
- R5: An acknowledge with `ack_pec`=1 clears the pending flag of source `ack_src` when `ack_cnt_zero`=0. When `ack_cnt_zero`=1 the flag stays set, so a CPU interrupt for that source follows.
- R6: A software write of 1 to bit 7 makes a request pending, and a write of 0 to bit 7 withdraws it.
- R7: Only sources whose enable and pending bits are both 1 take part in arbitration.
- R8: Among candidates, the one with the numerically highest priority level wins (0xF highest, 0x0 lowest).
- R9: Among candidates with equal priority level, the highest group level wins (3 highest, 0 lowest).
- R10: Among candidates with equal priority and group levels, the lowest source index wins.
- R11: `irq_valid` is 1 only when the winner's priority level is strictly greater than `cpu_level`. A level-0 request therefore never raises `irq_valid`.
- R12: If a hardware request and an acknowledge clear hit the same flag in the same cycle, the flag ends up set.
- R13: `irq_valid`, `irq_src` and `irq_level` follow a change of control state one clock edge later.
- R14: Writes to addresses at or above the number of sources have no effect, and reads from such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NSRC (8) | Per-source request pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDXW (3) | Source index for register read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data of the addressed word |
| cpu_level | input | 4 | Priority level the CPU is currently running at |
| ack_valid | input | 1 | Service entry for source `ack_src` |
| ack_src | input | IDXW (3) | Source being serviced |
| ack_pec | input | 1 | 1 = event-controller transfer, 0 = CPU interrupt |
| ack_cnt_zero | input | 1 | Event-controller transfer count reached zero |
| irq_valid | output | 1 | A winner exists above `cpu_level` |
| irq_src | output | IDXW (3) | Winning source index |
| irq_level | output | 4 | Winning priority level |

## Verification
The bench targets the places where ordering matters. Equal-level sources are split by group level, and a full tie must go to the lowest index; a comparator with `>=` would hand it to the highest index instead. It pairs event-controller acknowledges with and without the count-zero marker, since a design that always cleared the flag would drop the CPU interrupt at the end of a block transfer. It also lands a request and an acknowledge on the same cycle, where a design that let the clear win would lose that request. Finally it sweeps the CPU level around the winner's level, including level 0, to catch a `>=` where `>` belongs. It checks the one-cycle output latency, and it runs a long pseudo-random sweep of all control words against an arithmetic model.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int PRIO_W = 4;
   localparam int GRP_W  = 2;
   localparam int WORD_W = 16;
   localparam int CTRL_W = 2 + PRIO_W + GRP_W;
   localparam int KEY_W  = PRIO_W + GRP_W;

   // Field order sets bit positions: pend=7, en=6, prio=5:2, grp=1:0
   typedef struct packed {
      logic              pend;
      logic              en;
      logic [PRIO_W-1:0] prio;
      logic [GRP_W-1:0]  grp;
   } irq_ctrl_t;
endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg
   import irq_prio_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      set_i,
   input  logic      wr_i,
   input  irq_ctrl_t wdata_i,
   input  logic      clr_i,
   output irq_ctrl_t ctrl_o
);
   irq_ctrl_t ctrl_q;
   irq_ctrl_t ctrl_nxt;

   // Precedence, lowest first: service clear, software write, hardware set
   always_comb begin
      ctrl_nxt = ctrl_q;
      if (clr_i) ctrl_nxt.pend = 1'b0;
      if (wr_i)  ctrl_nxt      = wdata_i;
      if (set_i) ctrl_nxt.pend = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_nxt;
   end

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_prio_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int IDXW = 3
)(
   input  logic [NSRC-1:0]             cand_i,
   input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [NSRC-1:0][GRP_W-1:0]  grp_i,
   output logic                        found_o,
   output logic [IDXW-1:0]             idx_o,
   output logic [PRIO_W-1:0]           prio_o
);
   logic [KEY_W-1:0] best_key;
   logic [KEY_W-1:0] cur_key;

   // Ascending scan with strict compare: a full tie keeps the lower index
   always_comb begin
      found_o  = 1'b0;
      idx_o    = '0;
      best_key = '0;
      cur_key  = '0;
      for (int i = 0; i < NSRC; i++) begin
         cur_key = {prio_i[i], grp_i[i]};
         if (cand_i[i] && (!found_o || (cur_key > best_key))) begin
            found_o  = 1'b1;
            idx_o    = IDXW'(i);
            best_key = cur_key;
         end
      end
      prio_o = best_key[KEY_W-1:GRP_W];
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter  int NSRC = 8,
   localparam int IDXW = (NSRC < 2) ? 1 : $clog2(NSRC)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   hw_req,
   input  logic              reg_we,
   input  logic [IDXW-1:0]   reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic [PRIO_W-1:0] cpu_level,
   input  logic              ack_valid,
   input  logic [IDXW-1:0]   ack_src,
   input  logic              ack_pec,
   input  logic              ack_cnt_zero,
   output logic              irq_valid,
   output logic [IDXW-1:0]   irq_src,
   output logic [PRIO_W-1:0] irq_level
);
   generate
      if (NSRC < 2 || NSRC > 256) begin : g_bad_nsrc
         $error("irq_prio_ctrl: NSRC must lie in 2..256");
      end
   endgenerate

   irq_ctrl_t                   ctrl [NSRC];
   logic [NSRC-1:0]             src_en;
   logic [NSRC-1:0]             src_pend;
   logic [NSRC-1:0][PRIO_W-1:0] src_prio;
   logic [NSRC-1:0][GRP_W-1:0]  src_grp;
   logic                        clr_ok;

   // Event-controller transfer that exhausted its count keeps the flag
   assign clr_ok = ack_valid && !(ack_pec && ack_cnt_zero);

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         logic wr_hit;
         logic clr_hit;
         assign wr_hit  = reg_we && (reg_addr == IDXW'(g));
         assign clr_hit = clr_ok && (ack_src == IDXW'(g));

         irq_src_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (hw_req[g]),
            .wr_i    (wr_hit),
            .wdata_i (irq_ctrl_t'(reg_wdata[CTRL_W-1:0])),
            .clr_i   (clr_hit),
            .ctrl_o  (ctrl[g])
         );

         assign src_en[g]   = ctrl[g].en;
         assign src_pend[g] = ctrl[g].pend;
         assign src_prio[g] = ctrl[g].prio;
         assign src_grp[g]  = ctrl[g].grp;
      end
   endgenerate

   // Read mux; unmatched addresses fall through to zero
   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (reg_addr == IDXW'(i))
            reg_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl[i]};
      end
   end

   logic              win_found;
   logic [IDXW-1:0]   win_idx;
   logic [PRIO_W-1:0] win_prio;

   irq_arbiter #(
      .NSRC (NSRC),
      .IDXW (IDXW)
   ) u_arb (
      .cand_i  (src_en & src_pend),
      .prio_i  (src_prio),
      .grp_i   (src_grp),
      .found_o (win_found),
      .idx_o   (win_idx),
      .prio_o  (win_prio)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_src   <= '0;
         irq_level <= '0;
      end else begin
         irq_valid <= win_found && (win_prio > cpu_level);
         irq_src   <= win_idx;
         irq_level <= win_prio;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter  int NSRC = 8,
   localparam int IDXW = (NSRC < 2) ? 1 : $clog2(NSRC)
)(
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] hw_req,
   input logic            reg_we,
   input logic [IDXW-1:0] reg_addr,
   input logic [3:0]      cpu_level,
   input logic            ack_valid,
   input logic [IDXW-1:0] ack_src,
   input logic            ack_pec,
   input logic            ack_cnt_zero,
   input logic            irq_valid,
   input logic [IDXW-1:0] irq_src,
   input logic [3:0]      irq_level,
   input logic [NSRC-1:0] src_en,
   input logic [NSRC-1:0] src_pend
);
   logic [NSRC-1:0] cand_d;
   logic [3:0]      cpu_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_d <= '0;
         cpu_d  <= '0;
      end else begin
         cand_d <= src_en & src_pend;
         cpu_d  <= cpu_level;
      end
   end

   // R7: a presented winner was enabled and pending one cycle earlier
   a_r7_winner_candidate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> cand_d[irq_src]);

   // R11: a presented level lies strictly above the CPU level it was compared with
   a_r11_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_level > cpu_d));

   // R4: a CPU acknowledge with no competing set or write clears the flag
   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_pec && !hw_req[ack_src] && !(reg_we && reg_addr == ack_src))
      |=> !src_pend[$past(ack_src)]);

   // R5: an event-controller transfer that exhausted its count keeps the flag
   a_r5_pec_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_pec && ack_cnt_zero && src_pend[ack_src]
       && !(reg_we && reg_addr == ack_src))
      |=> src_pend[$past(ack_src)]);

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_set
         // R12 and R3: a hardware request always leaves the flag set
         a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hw_req[g] |=> src_pend[g]);
      end
   endgenerate
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hw_req       (hw_req),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .cpu_level    (cpu_level),
   .ack_valid    (ack_valid),
   .ack_src      (ack_src),
   .ack_pec      (ack_pec),
   .ack_cnt_zero (ack_cnt_zero),
   .irq_valid    (irq_valid),
   .irq_src      (irq_src),
   .irq_level    (irq_level),
   .src_en       (src_en),
   .src_pend     (src_pend)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
   localparam int N = 5;
   localparam int W = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  hw_req = '0;
   logic          reg_we = 1'b0;
   logic [W-1:0]  reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic [3:0]    cpu_level = '0;
   logic          ack_valid = 1'b0;
   logic [W-1:0]  ack_src = '0;
   logic          ack_pec = 1'b0;
   logic          ack_cnt_zero = 1'b0;
   logic          irq_valid;
   logic [W-1:0]  irq_src;
   logic [3:0]    irq_level;

   int checks = 0;
   int errors = 0;
   logic [7:0]  mdl [N];
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   irq_prio_ctrl #(.NSRC(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_level(cpu_level), .ack_valid(ack_valid), .ack_src(ack_src),
      .ack_pec(ack_pec), .ack_cnt_zero(ack_cnt_zero), .irq_valid(irq_valid),
      .irq_src(irq_src), .irq_level(irq_level)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = W'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
      reg_addr = W'(a);
      #1;
      chk(req, {16'h0, reg_rdata}, {16'h0, exp});
   endtask

   task automatic settle;
      @(negedge clk);
   endtask

   task automatic pulse(input int s);
      @(negedge clk);
      hw_req = N'(1) << s;
      @(negedge clk);
      hw_req = '0;
   endtask

   task automatic ack(input int s, input logic pec, input logic cz, input logic also_req);
      @(negedge clk);
      ack_valid = 1'b1; ack_src = W'(s); ack_pec = pec; ack_cnt_zero = cz;
      if (also_req) hw_req = N'(1) << s;
      @(negedge clk);
      ack_valid = 1'b0; ack_pec = 1'b0; ack_cnt_zero = 1'b0; hw_req = '0;
   endtask

   task automatic chk_out(input string req, input logic v, input int s, input int lvl);
      chk(req, {31'h0, irq_valid}, {31'h0, v});
      if (v) begin
         chk(req, {29'h0, irq_src}, 32'(s));
         chk(req, {28'h0, irq_level}, 32'(lvl));
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic clear_all;
      for (int i = 0; i < N; i++) wr(i, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1: reset state
      for (int i = 0; i < N; i++) rd_chk("R1 reset word", i, 16'h0000);
      chk("R1 irq_valid after reset", {31'h0, irq_valid}, 32'h0);

      // R2: layout and upper byte read as zero
      wr(2, 16'hFFFF);
      rd_chk("R2 upper byte zero", 2, 16'h00FF);
      settle();
      chk_out("R2 full word source wins", 1'b1, 2, 15);
      wr(2, 16'h0000);
      wr(3, 16'hA537);
      rd_chk("R2 field readback", 3, 16'h0037);
      wr(3, 16'h0000);

      // R14: out-of-range addresses
      wr(6, 16'h00FF);
      wr(7, 16'h00DD);
      for (int i = 0; i < N; i++) rd_chk("R14 oob write no effect", i, 16'h0000);
      rd_chk("R14 oob read zero", 6, 16'h0000);
      rd_chk("R14 oob read zero", 7, 16'h0000);
      settle();
      chk("R14 no request from oob write", {31'h0, irq_valid}, 32'h0);

      // R3, R13: hardware set and output latency (en=bit6, prio 5 in bits 5:2)
      wr(1, 16'h0054);
      settle();
      chk("R7 enabled but not pending", {31'h0, irq_valid}, 32'h0);
      pulse(1);
      rd_chk("R3 hw pulse sets bit 7", 1, 16'h00D4);
      chk("R13 output not yet updated", {31'h0, irq_valid}, 32'h0);
      settle();
      chk_out("R13 output one edge later", 1'b1, 1, 5);

      // R11: strict comparison with cpu level
      cpu_level = 4'd5; settle();
      chk("R11 equal cpu level blocks", {31'h0, irq_valid}, 32'h0);
      cpu_level = 4'd15; settle();
      chk("R11 higher cpu level blocks", {31'h0, irq_valid}, 32'h0);
      cpu_level = 4'd4; settle();
      chk_out("R11 lower cpu level passes", 1'b1, 1, 5);
      cpu_level = 4'd0;

      // R4: CPU acknowledge clears
      ack(1, 1'b0, 1'b0, 1'b0);
      rd_chk("R4 cpu ack clears flag", 1, 16'h0054);
      settle();
      chk("R4 no request after ack", {31'h0, irq_valid}, 32'h0);

      // R5: event-controller acknowledge
      pulse(1);
      ack(1, 1'b1, 1'b0, 1'b0);
      rd_chk("R5 transfer clears flag", 1, 16'h0054);
      pulse(1);
      ack(1, 1'b1, 1'b1, 1'b0);
      rd_chk("R5 count zero keeps flag", 1, 16'h00D4);
      settle();
      chk_out("R5 cpu interrupt follows", 1'b1, 1, 5);
      ack(1, 1'b0, 1'b0, 1'b0);
      rd_chk("R4 follow-up cpu ack clears", 1, 16'h0054);

      // R12: set and clear in the same cycle
      ack(1, 1'b0, 1'b0, 1'b1);
      rd_chk("R12 set wins over clear (flag was 0)", 1, 16'h00D4);
      ack(1, 1'b0, 1'b0, 1'b1);
      rd_chk("R12 set wins over clear (flag was 1)", 1, 16'h00D4);

      // R6: software write of the flag
      wr(1, 16'h0054);
      rd_chk("R6 write 0 withdraws", 1, 16'h0054);
      settle();
      chk("R6 withdrawn request idle", {31'h0, irq_valid}, 32'h0);
      wr(1, 16'h00D4);
      rd_chk("R6 write 1 pends", 1, 16'h00D4);
      settle();
      chk_out("R6 written request presented", 1'b1, 1, 5);
      wr(1, 16'h0000);

      // R9: same level, group decides (0xDD: prio 7 grp 1, 0xDE: prio 7 grp 2)
      wr(0, 16'h00DD);
      wr(3, 16'h00DE);
      settle();
      chk_out("R9 higher group wins", 1'b1, 3, 7);
      // R8: higher level beats higher group (0xE0: prio 8 grp 0)
      wr(4, 16'h00E0);
      settle();
      chk_out("R8 higher level wins", 1'b1, 4, 8);
      // R7: disabled but pending does not compete (0xA0)
      wr(4, 16'h00A0);
      settle();
      chk_out("R7 disabled source ignored", 1'b1, 3, 7);
      // R10: full tie goes to lowest index
      for (int i = 0; i < N; i++) wr(i, 16'h00DD);
      settle();
      chk_out("R10 tie lowest index", 1'b1, 0, 7);
      wr(0, 16'h0000);
      settle();
      chk_out("R10 tie next lowest index", 1'b1, 1, 7);

      // R11: level 0 never raises a request
      clear_all();
      wr(2, 16'h00C3);
      settle();
      chk("R11 level 0 never valid", {31'h0, irq_valid}, 32'h0);
      clear_all();

      // R7 R8 R9 R10 R11: pseudo-random sweep against arithmetic model
      for (int it = 0; it < 300; it++) begin
         logic       ev;
         int         es;
         logic [5:0] ek;
         logic [5:0] k;
         seed = nxt(seed);
         cpu_level = (it % 3 == 0) ? 4'd0 : seed[3:0];
         for (int i = 0; i < N; i++) begin
            logic [15:0] d;
            seed = nxt(seed);
            d = seed[15:0];
            if (it % 2 == 1) d[5:4] = 2'b00;
            if (seed[20]) d[7:6] = 2'b11;
            mdl[i] = d[7:0];
            wr(i, d);
         end
         ev = 1'b0; es = 0; ek = '0;
         for (int i = 0; i < N; i++) begin
            k = mdl[i][5:0];
            if (mdl[i][7] && mdl[i][6] && (!ev || k > ek)) begin
               ev = 1'b1; es = i; ek = k;
            end
         end
         ev = ev && (ek[5:2] > cpu_level);
         settle();
         chk_out("R8 R9 R10 sweep", ev, es, int'(ek[5:2]));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule